// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table held in memory. A translation request enters through a valid/ready handshake. The walker splits the address into three fields: a directory index (top 10 bits), a table index (middle 10 bits) and a 12-bit byte offset within a 4 KB page. It then makes two reads, one after the other. The first read fetches the directory entry, and that entry names the frame that holds the second-level table. The second read fetches the leaf entry, which names the target frame. The offset is placed below that frame number unchanged.

Memory is reached through one read port. The request side uses valid/ready. While `rd_req_valid` is high and `rd_req_ready` is low, the walker holds both the valid and the address steady. A request is accepted on a cycle where both are high. Only one read is in flight at a time. The response carries no back-pressure and may arrive any number of cycles after acceptance. A new translation is accepted only while the walker is idle (`req_ready` high), so an upstream source must hold its request until then. The result appears as a one-cycle pulse on either `walk_done` or `walk_fault`. The registered `walk_pa` and `fault_code` hold until the next result.

Entries are 32 bits wide with this layout:
- bits [31:12]: frame number
- bit 3: execute allowed
- bit 2: write allowed
- bit 1: read allowed
- bit 0: present

Top module: `two_level_walker`

## Requirements
- R1: The first read of every walk goes to `ptbr + dir_idx*4`, where `dir_idx = req_va[31:22]`.
- R2: When the directory entry is present, the second read goes to `dir_frame*4096 + tbl_idx*4`, where `dir_frame = entry[31:12]` and `tbl_idx = req_va[21:12]`. The walk makes exactly two reads.
- R3: On success, `walk_done` pulses and `walk_pa = {leaf_frame, req_va[11:0]}`, with `fault_code = 0`.
- R4: A directory entry with bit 0 clear ends the walk after one read. `walk_fault` pulses with `fault_code = 1` and no second read is issued.
- R5: A leaf entry with bit 0 clear raises `walk_fault` with `fault_code = 2`.
- R6: The leaf entry must grant the access type, otherwise `fault_code = 3`. Access type 0 (load) needs bit 1, type 1 (store) needs bit 2 and type 2 (fetch) needs bit 3. Type 3 is always refused. Permission bits in the directory entry have no effect.
- R7: `req_ready` is high only when idle. A request offered during a walk is not taken until the walk has finished, and it issues no reads before then.
- R8: While a read request is stalled by `rd_req_ready` low, `rd_req_valid` and `rd_addr` stay unchanged. Any response latency is tolerated.
- R9: After reset the walker is idle: `req_ready` is 1, and `rd_req_valid`, `walk_done` and `walk_fault` are 0.
- R10: `walk_done` and `walk_fault` are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptbr | input | 32 | Byte address of the directory table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 32 | Logical address to translate |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 reserved |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | 32 | Byte address of the entry to read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Entry returned by memory |
| walk_done | output | 1 | One-cycle pulse: translation succeeded |
| walk_fault | output | 1 | One-cycle pulse: translation failed |
| walk_pa | output | 32 | Physical address of the last successful walk |
| fault_code | output | 2 | 0 none, 1 directory absent, 2 leaf absent, 3 permission |

## Verification
The bench builds the walker with its default parameters: 10-bit indices, a 12-bit offset and 32-bit entries. With these values the all-ones address reaches the last directory slot and the last leaf slot, and the all-zero address reaches the first. The memory model varies response latency from zero to eight cycles and can stall request acceptance. This exercises the hold rule and the wait in each read state. Every access type meets entries that grant and entries that refuse it, and a second request is held at the input during a slow walk.

// File: rtl/walker_pkg.sv
package walker_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_DIR  = 2'd1,
    FLT_LEAF = 2'd2,
    FLT_PERM = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR,
    ST_LEAF,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  // entry layout: present flag, then one grant bit per access type
  localparam int PTE_PRESENT_BIT = 0;
  localparam int PTE_PERM_LO     = 1;
  localparam int PTE_NUM_PERM    = 3;

endpackage

// File: rtl/va_fields.sv
module va_fields #(
  parameter int ADDR_W    = 32,
  parameter int DIR_IDX_W = 10,
  parameter int TBL_IDX_W = 10,
  parameter int OFF_W     = 12
) (
  input  logic [ADDR_W-1:0]    va,
  output logic [DIR_IDX_W-1:0] dir_idx,
  output logic [TBL_IDX_W-1:0] tbl_idx,
  output logic [OFF_W-1:0]     off
);
  localparam int TBL_LO = OFF_W;
  localparam int DIR_LO = OFF_W + TBL_IDX_W;

  assign off     = va[OFF_W-1:0];
  assign tbl_idx = va[TBL_LO +: TBL_IDX_W];
  assign dir_idx = va[DIR_LO +: DIR_IDX_W];
endmodule

// File: rtl/pte_decode.sv
module pte_decode
  import walker_pkg::*;
#(
  parameter int PTE_W   = 32,
  parameter int FRAME_W = 20
) (
  input  logic [PTE_W-1:0]   pte,
  input  logic [1:0]         acc,
  output logic               present,
  output logic               granted,
  output logic [FRAME_W-1:0] frame
);
  localparam int FRAME_LO = PTE_W - FRAME_W;

  logic [PTE_NUM_PERM-1:0] perm;
  logic [PTE_NUM_PERM-1:0] need;
  logic                    pte_unused;

  assign perm    = pte[PTE_PERM_LO +: PTE_NUM_PERM];
  assign present = pte[PTE_PRESENT_BIT];
  assign frame   = pte[FRAME_LO +: FRAME_W];

  // one request bit per grantable access type; the reserved code sets none
  for (genvar g = 0; g < PTE_NUM_PERM; g++) begin : g_need
    assign need[g] = (acc == 2'(g));
  end

  assign granted    = present && |(need & perm);
  assign pte_unused = ^pte[FRAME_LO-1:PTE_PERM_LO+PTE_NUM_PERM];
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walker_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_va,
  input  logic [1:0]         req_acc,
  output logic               req_ready,
  output logic [ADDR_W-1:0]  va_q,
  output logic [1:0]         acc_q,
  output logic [FRAME_W-1:0] dir_frame_q,
  input  logic [ADDR_W-1:0]  dir_addr,
  input  logic [ADDR_W-1:0]  leaf_addr,
  input  logic [ADDR_W-1:0]  leaf_pa,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic               rd_rsp_valid,
  input  logic               pte_present,
  input  logic               pte_granted,
  input  logic [FRAME_W-1:0] pte_frame,
  output logic               walk_done,
  output logic               walk_fault,
  output logic [ADDR_W-1:0]  walk_pa,
  output logic [1:0]         fault_code
);
  walk_state_e state;
  logic        sent;
  logic        rsp_take;

  assign req_ready    = (state == ST_IDLE);
  assign rd_req_valid = ((state == ST_DIR) || (state == ST_LEAF)) && !sent;
  assign rd_addr      = (state == ST_LEAF) ? leaf_addr : dir_addr;
  assign rsp_take     = sent && rd_rsp_valid;
  assign walk_done    = (state == ST_DONE);
  assign walk_fault   = (state == ST_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      sent        <= 1'b0;
      va_q        <= '0;
      acc_q       <= '0;
      dir_frame_q <= '0;
      walk_pa     <= '0;
      fault_code  <= FLT_NONE;
    end else begin
      if (rd_req_valid && rd_req_ready) sent <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q  <= req_va;
            acc_q <= req_acc;
            sent  <= 1'b0;
            state <= ST_DIR;
          end
        end
        ST_DIR: begin
          if (rsp_take) begin
            sent <= 1'b0;
            if (!pte_present) begin
              fault_code <= FLT_DIR;
              walk_pa    <= '0;
              state      <= ST_FAULT;
            end else begin
              dir_frame_q <= pte_frame;
              state       <= ST_LEAF;
            end
          end
        end
        ST_LEAF: begin
          if (rsp_take) begin
            sent <= 1'b0;
            if (!pte_present) begin
              fault_code <= FLT_LEAF;
              walk_pa    <= '0;
              state      <= ST_FAULT;
            end else if (!pte_granted) begin
              fault_code <= FLT_PERM;
              walk_pa    <= '0;
              state      <= ST_FAULT;
            end else begin
              fault_code <= FLT_NONE;
              walk_pa    <= leaf_pa;
              state      <= ST_DONE;
            end
          end
        end
        ST_DONE:  state <= ST_IDLE;
        ST_FAULT: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/two_level_walker.sv
module two_level_walker #(
  parameter int ADDR_W    = 32,
  parameter int DIR_IDX_W = 10,
  parameter int TBL_IDX_W = 10,
  parameter int OFF_W     = 12,
  parameter int PTE_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ptbr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [1:0]        req_acc,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [PTE_W-1:0]  rd_rsp_data,
  output logic              walk_done,
  output logic              walk_fault,
  output logic [ADDR_W-1:0] walk_pa,
  output logic [1:0]        fault_code
);
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int PTE_SH  = $clog2(PTE_W / 8);

  logic [ADDR_W-1:0]    va_q;
  logic [1:0]           acc_q;
  logic [FRAME_W-1:0]   dir_frame_q;
  logic [DIR_IDX_W-1:0] dir_idx;
  logic [TBL_IDX_W-1:0] tbl_idx;
  logic [OFF_W-1:0]     off;
  logic                 pte_present;
  logic                 pte_granted;
  logic [FRAME_W-1:0]   pte_frame;
  logic [ADDR_W-1:0]    dir_addr;
  logic [ADDR_W-1:0]    leaf_addr;
  logic [ADDR_W-1:0]    leaf_pa;

  va_fields #(
    .ADDR_W(ADDR_W), .DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W), .OFF_W(OFF_W)
  ) u_fields (
    .va(va_q), .dir_idx(dir_idx), .tbl_idx(tbl_idx), .off(off)
  );

  pte_decode #(.PTE_W(PTE_W), .FRAME_W(FRAME_W)) u_decode (
    .pte(rd_rsp_data), .acc(acc_q),
    .present(pte_present), .granted(pte_granted), .frame(pte_frame)
  );

  // directory slot: base register plus scaled index
  assign dir_addr  = ptbr + (ADDR_W'(dir_idx) << PTE_SH);
  // leaf slot: table frame start plus scaled index
  assign leaf_addr = (ADDR_W'(dir_frame_q) << OFF_W) + (ADDR_W'(tbl_idx) << PTE_SH);
  // offset is placed below the frame, never added
  assign leaf_pa   = {pte_frame, off};

  walk_ctrl #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_va(req_va), .req_acc(req_acc), .req_ready(req_ready),
    .va_q(va_q), .acc_q(acc_q), .dir_frame_q(dir_frame_q),
    .dir_addr(dir_addr), .leaf_addr(leaf_addr), .leaf_pa(leaf_pa),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid),
    .pte_present(pte_present), .pte_granted(pte_granted), .pte_frame(pte_frame),
    .walk_done(walk_done), .walk_fault(walk_fault),
    .walk_pa(walk_pa), .fault_code(fault_code)
  );
endmodule

// File: rtl/walker_chk.sv
module walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              walk_done,
  input logic              walk_fault,
  input logic [1:0]        fault_code
);
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !req_ready);

  // R10
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(walk_done && walk_fault));

  // R10
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done || walk_fault) |=> !(walk_done || walk_fault));

  // R4
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_fault |-> (fault_code != 2'd0));

  // R3
  done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> (fault_code == 2'd0));
endmodule

bind two_level_walker walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
  .walk_done(walk_done), .walk_fault(walk_fault), .fault_code(fault_code)
);

// File: tb/two_level_walker_bench.sv
`timescale 1ns/1ps
module two_level_walker_bench;
  localparam logic [31:0] PTBR = 32'h0004_0000;

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic [31:0] dpte;
    logic [31:0] lpte;
    logic [1:0]  code;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [0:NV-1] = '{
    '{32'h0040_1ABC, 2'd0, 32'h0012_3001, 32'h0ABC_D003, 2'd0, 32'h0ABC_DABC},
    '{32'hFFFF_FFFF, 2'd1, 32'h0007_7001, 32'h0055_5005, 2'd0, 32'h0055_5FFF},
    '{32'h0000_0000, 2'd2, 32'h0000_1001, 32'h0009_9009, 2'd0, 32'h0009_9000},
    '{32'h1234_5678, 2'd0, 32'h0012_3000, 32'h0077_7003, 2'd1, 32'h0000_0000},
    '{32'h0080_2010, 2'd0, 32'h0020_0001, 32'h0030_0006, 2'd2, 32'h0000_0000},
    '{32'h00C0_3004, 2'd1, 32'h0020_1001, 32'h0040_0003, 2'd3, 32'h0000_0000},
    '{32'h00C0_3008, 2'd2, 32'h0020_1001, 32'h0040_0007, 2'd3, 32'h0000_0000},
    '{32'h00C0_300C, 2'd3, 32'h0020_1001, 32'h0040_000F, 2'd3, 32'h0000_0000},
    '{32'h00C0_3010, 2'd0, 32'h0020_1001, 32'h0040_0009, 2'd3, 32'h0000_0000},
    '{32'h3FF0_0ABC, 2'd0, 32'h00AB_C00F, 32'h0FED_C00F, 2'd0, 32'h0FED_CABC}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        rd_req_valid;
  logic        rd_req_ready;
  logic [31:0] rd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic        walk_done;
  logic        walk_fault;
  logic [31:0] walk_pa;
  logic [1:0]  fault_code;

  int checks = 0;
  int errors = 0;

  // memory model state
  logic [31:0] m_a0 = '0, m_d0 = '0, m_a1 = '0, m_d1 = '0;
  int          lat = 0;
  logic        stall_en = 1'b0;
  logic [1:0]  tick = '0;
  logic        m_busy = 1'b0;
  int          m_cnt = 0;
  logic [31:0] m_addr = '0;
  int          nreads = 0;
  logic [31:0] rd_log [0:63];

  always #2.5 clk = ~clk;

  two_level_walker u_two_level_walker (
    .clk(clk), .rst_n(rst_n), .ptbr(PTBR),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_acc(req_acc),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .walk_done(walk_done), .walk_fault(walk_fault),
    .walk_pa(walk_pa), .fault_code(fault_code)
  );

  function automatic logic [31:0] mem_read(input logic [31:0] a);
    if (a == m_a0) return m_d0;
    if (a == m_a1) return m_d1;
    return 32'hDEAD_0000;
  endfunction

  assign rd_req_ready = !stall_en || (tick == 2'd3);

  always @(posedge clk) begin
    tick         <= tick + 2'd1;
    rd_rsp_valid <= 1'b0;
    if (m_busy) begin
      if (m_cnt == 0) begin
        rd_rsp_valid <= 1'b1;
        rd_rsp_data  <= mem_read(m_addr);
        m_busy       <= 1'b0;
      end else begin
        m_cnt <= m_cnt - 1;
      end
    end
    if (rd_req_valid && rd_req_ready) begin
      m_addr               <= rd_addr;
      m_cnt                <= lat;
      m_busy               <= 1'b1;
      rd_log[nreads % 64]  <= rd_addr;
      nreads               <= nreads + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_mem(input vec_t v);
    m_a0 = PTBR + {20'd0, v.va[31:22], 2'b00};
    m_d0 = v.dpte;
    m_a1 = {v.dpte[31:12], 12'd0} + {20'd0, v.va[21:12], 2'b00};
    m_d1 = v.lpte;
  endtask

  task automatic wait_result(output bit seen);
    int cyc = 0;
    while (!(walk_done || walk_fault) && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    seen = walk_done || walk_fault;
  endtask

  task automatic check_result(input vec_t v, input int start, input string tag);
    int exp_reads;
    exp_reads = (v.code == 2'd1) ? 1 : 2;
    if (v.code == 2'd0) begin
      // R3
      chk(walk_done && !walk_fault, {tag, " R3 done"}, {30'd0, walk_done, walk_fault}, 32'd2);
      chk(walk_pa == v.pa, {tag, " R3 pa"}, walk_pa, v.pa);
    end else begin
      // R4 R5 R6: fault code by cause
      chk(walk_fault && !walk_done, {tag, " R4/R5/R6 fault"}, {30'd0, walk_done, walk_fault}, 32'd1);
      chk(fault_code == v.code, {tag, " R6 code"}, {30'd0, fault_code}, {30'd0, v.code});
    end
    // R1
    chk(rd_log[start % 64] == m_a0, {tag, " R1 dir addr"}, rd_log[start % 64], m_a0);
    // R2 (two reads) or R4 (one read)
    chk(nreads - start == exp_reads, {tag, " R2/R4 read count"}, 32'(nreads - start),
        32'(exp_reads));
    if (exp_reads == 2)
      chk(rd_log[(start + 1) % 64] == m_a1, {tag, " R2 leaf addr"}, rd_log[(start + 1) % 64], m_a1);
    @(negedge clk);
    // R10
    chk(!walk_done && !walk_fault, {tag, " R10 pulse"}, {30'd0, walk_done, walk_fault}, 32'd0);
  endtask

  task automatic run_walk(input vec_t v, input string tag);
    int  start;
    bit  seen;
    load_mem(v);
    start = nreads;
    @(negedge clk);
    req_va = v.va; req_acc = v.acc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_result(seen);
    if (!seen) chk(1'b0, {tag, " R8 timeout"}, 32'd0, 32'd1);
    else       check_result(v, start, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int  start;
    bit  seen;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(req_ready == 1'b1, "R9 req_ready", {31'd0, req_ready}, 32'd1);
    chk(!rd_req_valid && !walk_done && !walk_fault, "R9 outputs idle",
        {29'd0, rd_req_valid, walk_done, walk_fault}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      lat      = i % 4;
      stall_en = (i % 2) == 1;
      run_walk(VECS[i], $sformatf("vec%0d", i));
    end

    // R8: long latency with stalled acceptance
    lat = 8; stall_en = 1'b1;
    run_walk(VECS[1], "slow R8");

    // R7: second request held during a walk
    lat = 6; stall_en = 1'b0;
    load_mem(VECS[0]);
    start = nreads;
    req_va = VECS[0].va; req_acc = VECS[0].acc; req_valid = 1'b1;
    @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      chk(!req_ready, "R7 busy not ready", {31'd0, req_ready}, 32'd0);
    end
    wait_result(seen);
    chk(seen && nreads - start == 2, "R7 no extra read while busy",
        32'(nreads - start), 32'd2);
    @(negedge clk);
    chk(req_ready, "R7 ready after result", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    wait_result(seen);
    chk(seen && walk_done && walk_pa == VECS[0].pa, "R7 held request served",
        walk_pa, VECS[0].pa);
    chk(nreads - start == 4, "R7 total reads", 32'(nreads - start), 32'd4);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule